// File: doc/BRIEF.md
# Character LCD Write Sequencer

This block lets logic running on a fast system clock write to a character LCD module with the common 44780-style instruction set. A client gives one byte at a time over a valid/ready handshake, together with a flag that says whether the byte is an instruction or a character code for display memory. The block then drives the register-select, read/write, enable and data lines itself. It sets up the lines, gives one timed enable pulse, holds the lines, and then waits out the execution time of the byte. Every wait is made with a cycle counter. When the wait ends, it raises ready again.

The execution wait depends on the byte. A clear-display instruction gets a long wait. Every other instruction and every character write gets a short wait. A parameter selects the bus width. With an 8-bit bus the whole byte goes out in one transfer. With a 4-bit bus the byte goes out as two timed transfers on the upper four data lines, the high nibble first, with a gap between the two. A constant output holds the chip enable of a flash device that shares the data pins in its disabled state.

Top module: `lcd_write_seq`

## Requirements
- R1: Register-select (`lcd_rs`) is 0 for an instruction (`in_is_data`=0) and 1 for a character code (`in_is_data`=1). It holds that value for the whole transfer. `lcd_rw` is 0 at all times.
- R2: With an 8-bit bus, `lcd_d` carries the accepted byte unchanged from the cycle after acceptance until ready returns.
- R3: After acceptance, `lcd_e` stays low for SETUP_CYC cycles. It is then high for exactly PULSE_CYC cycles and low for at least HOLD_CYC cycles before the data lines may change. `lcd_rs` and `lcd_d` do not change while `lcd_e` is high.
- R4: `in_ready` is low from the cycle after acceptance until the final wait has ended. For an 8-bit bus it stays low for SETUP_CYC+PULSE_CYC+HOLD_CYC+W cycles, and for a 4-bit bus for 2·(SETUP_CYC+PULSE_CYC+HOLD_CYC)+GAP_CYC+W cycles. `lcd_e` is never high while ready is high.
- R5: W is CLEAR_WAIT only for the instruction 0x01 sent with `in_is_data`=0. Every other byte uses SHORT_WAIT, including 0x01 sent as data and the display-shift instructions 0x18 to 0x1B.
- R6: With a 4-bit bus, `lcd_d[7:4]` first carries byte bits 7..4 and then byte bits 3..0, each nibble with its own enable pulse. The high nibble stays on the bus through its hold and a GAP_CYC gap. `lcd_d[3:0]` is 0.
- R7: `flash_ce_off` is 1 at all times.
- R8: While `rst` is high at a clock edge, the block returns to idle: `lcd_e`=0, `in_ready`=1, `lcd_rs`=0 and `lcd_d`=0. This also holds in the middle of a transfer.
- R9: `in_valid`, `in_code` and `in_is_data` have no effect while ready is low. The byte on the bus does not change, and no further transfer starts once ready returns if valid has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered |
| in_is_data | input | 1 | 1: character code, 0: instruction |
| in_code | input | 8 | Byte to write |
| in_ready | output | 1 | Block is idle and takes a byte |
| lcd_rs | output | 1 | Register select to the LCD |
| lcd_rw | output | 1 | Read/write to the LCD, always 0 |
| lcd_e | output | 1 | Enable strobe to the LCD |
| lcd_d | output | 8 | Data lines to the LCD |
| flash_ce_off | output | 1 | Disable level for the shared flash chip enable |

## Verification
The bench builds two copies of the block. One uses an 8-bit bus and the other a 4-bit bus. Both use shrunken timing: setup 2, pulse 3, hold 1, gap 2, short wait 5 and clear wait 17 cycles. With these counts, each of the 256 byte values can be sent both as an instruction and as data on both bus widths in a few thousand cycles. Each cycle of every transfer is compared with the enable, data and ready waveform computed from these counts. That comparison covers the clear-versus-other wait split and the nibble order. Valid is also raised during some transfers, and reset is pulsed in the middle of a long clear.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic       is_data;
        logic [7:0] code;
    } lcd_req_t;

    localparam logic [7:0] CMD_CLEAR = 8'h01;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic needs_long_wait(input lcd_req_t r);
        return (!r.is_data) && (r.code == CMD_CLEAR);
    endfunction

    function automatic logic [7:0] bus_value(input lcd_req_t r, input logic four,
                                             input logic low_half);
        if (!four)
            return r.code;
        return low_half ? {r.code[3:0], 4'h0} : {r.code[7:4], 4'h0};
    endfunction

endpackage

// File: rtl/lcdw_timer.sv
module lcdw_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)) else $error("timer step"); // R4

endmodule

// File: rtl/lcdw_wait_sel.sv
module lcdw_wait_sel
    import lcdw_pkg::*;
#(
    parameter int CW         = 8,
    parameter int SHORT_WAIT = 5,
    parameter int CLEAR_WAIT = 17
) (
    input  lcd_req_t      req,
    output logic [CW-1:0] wait_m1
);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_WAIT - 1);
    localparam logic [CW-1:0] CLEAR_M1 = CW'(CLEAR_WAIT - 1);

    always_comb begin
        wait_m1 = needs_long_wait(req) ? CLEAR_M1 : SHORT_M1;
    end

endmodule

// File: rtl/lcd_write_seq.sv
module lcd_write_seq
    import lcdw_pkg::*;
#(
    parameter bit FOUR_BIT   = 1'b0,
    parameter int SETUP_CYC  = 2,
    parameter int PULSE_CYC  = 12,
    parameter int HOLD_CYC   = 1,
    parameter int GAP_CYC    = 50,
    parameter int SHORT_WAIT = 2000,
    parameter int CLEAR_WAIT = 250000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_is_data,
    input  logic [7:0] in_code,
    output logic       in_ready,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_d,
    output logic       flash_ce_off
);
    localparam int MAX_CYC = imax(imax(imax(SETUP_CYC, PULSE_CYC), imax(HOLD_CYC, GAP_CYC)),
                                  imax(SHORT_WAIT, CLEAR_WAIT));
    localparam int CW = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] SETUP_M1 = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] PULSE_M1 = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_M1  = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] GAP_M1   = CW'(GAP_CYC - 1);

    seq_state_e    state, nxt_state;
    lcd_req_t      req_q;
    logic          second_q;
    logic          t_load, t_done;
    logic [CW-1:0] t_val, wait_m1;

    lcdw_wait_sel #(
        .CW(CW), .SHORT_WAIT(SHORT_WAIT), .CLEAR_WAIT(CLEAR_WAIT)
    ) u_wait (
        .req(req_q), .wait_m1(wait_m1)
    );

    lcdw_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    always_comb begin
        nxt_state = state;
        t_load    = 1'b0;
        t_val     = '0;
        unique case (state)
            ST_IDLE: if (in_valid) begin
                nxt_state = ST_SETUP; t_load = 1'b1; t_val = SETUP_M1;
            end
            ST_SETUP: if (t_done) begin
                nxt_state = ST_PULSE; t_load = 1'b1; t_val = PULSE_M1;
            end
            ST_PULSE: if (t_done) begin
                nxt_state = ST_HOLD; t_load = 1'b1; t_val = HOLD_M1;
            end
            ST_HOLD: if (t_done) begin
                t_load = 1'b1;
                if (FOUR_BIT && !second_q) begin
                    nxt_state = ST_GAP; t_val = GAP_M1;
                end else begin
                    nxt_state = ST_WAIT; t_val = wait_m1;
                end
            end
            ST_GAP: if (t_done) begin
                nxt_state = ST_SETUP; t_load = 1'b1; t_val = SETUP_M1;
            end
            ST_WAIT: if (t_done) nxt_state = ST_IDLE;
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            second_q <= 1'b0;
        end else begin
            state <= nxt_state;
            if (state == ST_IDLE && in_valid) begin
                req_q    <= '{is_data: in_is_data, code: in_code};
                second_q <= 1'b0;
            end else if (state == ST_GAP && t_done) begin
                second_q <= 1'b1;
            end
        end
    end

    assign in_ready     = (state == ST_IDLE);
    assign lcd_e        = (state == ST_PULSE);
    assign lcd_rs       = req_q.is_data;
    assign lcd_d        = bus_value(req_q, FOUR_BIT, second_q);
    assign lcd_rw       = 1'b0;
    assign flash_ce_off = 1'b1;

    AST_E_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        lcd_e |-> !in_ready) else $error("enable while idle"); // R4
    AST_BUS_STABLE_E: assert property (@(posedge clk) disable iff (rst)
        lcd_e |=> ($stable(lcd_d) && $stable(lcd_rs))) else $error("bus moved under enable"); // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> $stable(req_q)) else $error("byte changed while busy"); // R9
    AST_READY_AFTER_E_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(in_ready) |-> !$past(lcd_e)) else $error("ready straight after enable"); // R4

    generate
        if (FOUR_BIT) begin : g_nib
            AST_LOW_LINES_IDLE: assert property (@(posedge clk) disable iff (rst)
                lcd_e |-> (lcd_d[3:0] == 4'h0)) else $error("low lines driven"); // R6
        end
    endgenerate

endmodule

// File: tb/lcd_write_seq_tb.sv
module lcd_write_seq_tb;
    localparam int S = 2, P = 3, H = 1, G = 2, SHW = 5, CLR = 17;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v8 = 1'b0, v4 = 1'b0, in_isd = 1'b0, sel4 = 1'b0;
    logic [7:0] in_code = 8'h00;
    logic r8, rs8, rw8, e8, f8, r4, rs4, rw4, e4, f4;
    logic [7:0] d8, d4;
    int errors = 0, checks = 0, cyc = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    lcd_write_seq #(.FOUR_BIT(1'b0), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
        .GAP_CYC(G), .SHORT_WAIT(SHW), .CLEAR_WAIT(CLR)) u_dut (
        .clk(clk), .rst(rst), .in_valid(v8), .in_is_data(in_isd), .in_code(in_code),
        .in_ready(r8), .lcd_rs(rs8), .lcd_rw(rw8), .lcd_e(e8), .lcd_d(d8), .flash_ce_off(f8));

    lcd_write_seq #(.FOUR_BIT(1'b1), .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H),
        .GAP_CYC(G), .SHORT_WAIT(SHW), .CLEAR_WAIT(CLR)) u_dut4 (
        .clk(clk), .rst(rst), .in_valid(v4), .in_is_data(in_isd), .in_code(in_code),
        .in_ready(r4), .lcd_rs(rs4), .lcd_rw(rw4), .lcd_e(e4), .lcd_d(d4), .flash_ce_off(f4));

    wire       s_r  = sel4 ? r4 : r8;
    wire       s_rs = sel4 ? rs4 : rs8;
    wire       s_rw = sel4 ? rw4 : rw8;
    wire       s_e  = sel4 ? e4 : e8;
    wire       s_f  = sel4 ? f4 : f8;
    wire [7:0] s_d  = sel4 ? d4 : d8;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic xfer(input bit four, input logic [7:0] code, input bit isd, input bit poke);
        int w, t, p1s, p1e, p2s, p2e, sw;
        bit exp_e;
        logic [7:0] exp_d;
        string wr;
        w   = (!isd && code == 8'h01) ? CLR : SHW;
        wr  = (code == 8'h01 || code[7:2] == 6'b000110) ? "R5" : "R4";
        t   = four ? 2 * (S + P + H) + G + w : S + P + H + w;
        p1s = S + 1; p1e = S + P;
        p2s = 2 * S + P + H + G + 1; p2e = p2s + P - 1;
        sw  = S + P + H + G;
        @(negedge clk);
        sel4 = four; in_code = code; in_isd = isd;
        if (four) v4 = 1'b1; else v8 = 1'b1;
        @(negedge clk);
        v8 = 1'b0; v4 = 1'b0;
        for (int c = 1; c <= t + 1; c++) begin
            exp_e = (c >= p1s && c <= p1e) || (four && c >= p2s && c <= p2e);
            exp_d = !four ? code : ((c <= sw) ? {code[7:4], 4'h0} : {code[3:0], 4'h0});
            chk(s_e == exp_e, "R3", s_e, exp_e);
            chk(s_r == (c > t), wr, s_r, (c > t));
            chk(s_rw == 1'b0, "R1", s_rw, 0);
            chk(s_f == 1'b1, "R7", s_f, 1);
            if (c <= t) begin
                chk(s_d == exp_d, four ? "R6" : (poke ? "R9" : "R2"), s_d, exp_d);
                chk(s_rs == isd, "R1", s_rs, isd);
            end
            if (poke && c == 2) begin
                in_code = ~code; in_isd = ~isd;
                if (four) v4 = 1'b1; else v8 = 1'b1;
            end
            if (poke && c == t) begin
                v8 = 1'b0; v4 = 1'b0;
            end
            if (c <= t) @(negedge clk);
        end
        if (poke) begin
            repeat (3) begin
                @(negedge clk);
                chk(s_e == 1'b0 && s_r == 1'b1, "R9", {s_e, s_r}, 2'b01);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000 && !done_flag) begin
                done_flag = 1'b1;
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<=200000", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            sel4 = k[0];
            chk(s_e == 0 && s_r == 1 && s_rs == 0 && s_d == 0, "R8",
                {s_e, s_r, s_rs, s_d}, {3'b010, 8'h00});
        end
        rst = 1'b0;
        // R8: reset in the middle of a long clear
        @(negedge clk); sel4 = 1'b0; in_code = 8'h01; in_isd = 1'b0; v8 = 1'b1;
        @(negedge clk); v8 = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(s_e == 0 && s_r == 1 && s_rs == 0 && s_d == 0, "R8",
            {s_e, s_r, s_rs, s_d}, {3'b010, 8'h00});
        rst = 1'b0;
        for (int four = 0; four < 2; four++)
            for (int code = 0; code < 256; code++)
                for (int isd = 0; isd < 2; isd++)
                    xfer(four[0], code[7:0], isd[0], (code % 37) == 0);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule